// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block maps a physical address onto one of eight memory rows. Software describes the memory by giving each row an 8-bit boundary value. Each value is the cumulative upper limit of that row, counted in 8 MB units. A row starts where the last populated row below it ended, and row 0 starts at address 0. A row whose limit does not move the running limit is empty and takes no addresses. A zero boundary that appears after memory has begun stands for the 2 GB top of memory.

For each row, the decoder reports its start address and its size. For the incoming address, it reports which row claims it and a hit flag. The decode path is combinational. A parameter adds an output register, which gives one cycle of latency; the default build uses it.

Top module: `rbd_decoder`

## Requirements
- R1: A nonzero boundary value b gives a row limit of b shifted left by 23 bits (b times 8 MB). Row i's boundary sits in bits [8i+7:8i] of bnd_i.
- R2: Row 0 has base 0. Every other row has as its base the limit of the nearest populated row below it, or 0 when there is none.
- R3: A row whose limit equals the running limit is empty. It reports size 0, claims no addresses, and does not advance the running limit.
- R4: A zero boundary that follows a nonzero running limit means a limit of 2 GB (0x80000000). Later zero rows are then empty at base 0x80000000.
- R5: Zero boundaries that come before any nonzero one give empty rows at base 0.
- R6: An address hits a row when base <= address < limit. row_o gives the lowest-numbered row that does so, and hit_o is 1.
- R7: When no row claims the address, hit_o is 0 and row_o is 0.
- R8: Size is limit minus base, modulo 2^32. A row whose limit lies below its base claims no addresses.
- R9: With the output register enabled (the default), every output reflects the inputs sampled at the previous clock edge. While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bnd_i | input | 8x8 | Cumulative boundary per row, row i in bits [8i+7:8i] |
| addr_i | input | 32 | Physical address to decode |
| hit_o | output | 1 | Address falls inside some row |
| row_o | output | 3 | Index of the claiming row, 0 on a miss |
| base_o | output | 8x32 | Start address of each row |
| size_o | output | 8x32 | Limit minus base for each row |

## Verification
The hardest case to reach is two rows that claim the same address. In a well-formed table the rows never overlap, so the lowest-row priority only matters when the table is malformed. The stimulus builds one on purpose: a boundary drops below its predecessor, and the row after it then re-covers addresses that row 0 already owns. The bench then checks that row 0 wins, and that the descending row claims nothing despite its wrapped size. A second hard case is the 2 GB encoding, which needs a zero after a nonzero boundary. It is reached with a table whose row 4 is zero, followed by probes at 0x7FFFFFFF and 0x80000000.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
  localparam int unsigned RBD_ROWS       = 8;
  localparam int unsigned RBD_BND_W      = 8;
  localparam int unsigned RBD_ADDR_W     = 32;
  localparam int unsigned RBD_UNIT_SHIFT = 23;
  localparam int unsigned RBD_TOP_SHIFT  = 31;
endpackage

// File: rtl/rbd_map.sv
// Turns cumulative boundaries into per-row base, limit and size.
module rbd_map #(
  parameter int unsigned N          = rbd_pkg::RBD_ROWS,
  parameter int unsigned BND_W      = rbd_pkg::RBD_BND_W,
  parameter int unsigned ADDR_W     = rbd_pkg::RBD_ADDR_W,
  parameter int unsigned UNIT_SHIFT = rbd_pkg::RBD_UNIT_SHIFT,
  parameter int unsigned TOP_SHIFT  = rbd_pkg::RBD_TOP_SHIFT
) (
  input  logic [N-1:0][BND_W-1:0]  bnd_i,
  output logic [N-1:0][ADDR_W-1:0] base_o,
  output logic [N-1:0][ADDR_W-1:0] lim_o,
  output logic [N-1:0][ADDR_W-1:0] size_o
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(1) << TOP_SHIFT;

  // running limit of populated rows seen so far
  logic [N:0][ADDR_W-1:0] run;
  assign run[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_row
    logic [ADDR_W-1:0] raw, lim;
    logic              empty;
    assign raw   = ADDR_W'(bnd_i[g]) << UNIT_SHIFT;
    assign lim   = (bnd_i[g] == '0 && run[g] != '0) ? TOP : raw;
    assign empty = (lim == run[g]);
    assign run[g+1]  = empty ? run[g] : lim;
    assign base_o[g] = run[g];
    assign lim_o[g]  = lim;
    assign size_o[g] = lim - run[g];
  end
endmodule

// File: rtl/rbd_match.sv
// Per-row range compare and lowest-index priority pick.
module rbd_match #(
  parameter int unsigned N      = rbd_pkg::RBD_ROWS,
  parameter int unsigned ADDR_W = rbd_pkg::RBD_ADDR_W,
  localparam int unsigned ROW_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [N-1:0][ADDR_W-1:0] base_i,
  input  logic [N-1:0][ADDR_W-1:0] lim_i,
  output logic                     hit_o,
  output logic [ROW_W-1:0]         row_o
);
  logic [N-1:0] in_row;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign in_row[g] = (addr_i >= base_i[g]) && (addr_i < lim_i[g]);
  end

  always_comb begin
    hit_o = |in_row;
    row_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (in_row[i]) row_o = ROW_W'(i);
    end
  end
endmodule

// File: rtl/rbd_decoder.sv
module rbd_decoder #(
  parameter int unsigned N          = rbd_pkg::RBD_ROWS,
  parameter int unsigned BND_W      = rbd_pkg::RBD_BND_W,
  parameter int unsigned ADDR_W     = rbd_pkg::RBD_ADDR_W,
  parameter int unsigned UNIT_SHIFT = rbd_pkg::RBD_UNIT_SHIFT,
  parameter int unsigned TOP_SHIFT  = rbd_pkg::RBD_TOP_SHIFT,
  parameter bit          OUT_REG    = 1'b1,
  localparam int unsigned ROW_W     = (N > 1) ? $clog2(N) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0][BND_W-1:0]  bnd_i,
  input  logic [ADDR_W-1:0]        addr_i,
  output logic                     hit_o,
  output logic [ROW_W-1:0]         row_o,
  output logic [N-1:0][ADDR_W-1:0] base_o,
  output logic [N-1:0][ADDR_W-1:0] size_o
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(1) << TOP_SHIFT;

  logic [N-1:0][ADDR_W-1:0] base_c, lim_c, size_c;
  logic                     hit_c;
  logic [ROW_W-1:0]         row_c;

  rbd_map #(
    .N(N), .BND_W(BND_W), .ADDR_W(ADDR_W),
    .UNIT_SHIFT(UNIT_SHIFT), .TOP_SHIFT(TOP_SHIFT)
  ) u_map (
    .bnd_i (bnd_i),
    .base_o(base_c),
    .lim_o (lim_c),
    .size_o(size_c)
  );

  rbd_match #(.N(N), .ADDR_W(ADDR_W)) u_match (
    .addr_i(addr_i),
    .base_i(base_c),
    .lim_i (lim_c),
    .hit_o (hit_c),
    .row_o (row_c)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hit_o  <= 1'b0;
        row_o  <= '0;
        base_o <= '0;
        size_o <= '0;
      end else begin
        hit_o  <= hit_c;
        row_o  <= row_c;
        base_o <= base_c;
        size_o <= size_c;
      end
    end
  end else begin : g_comb
    assign hit_o  = hit_c;
    assign row_o  = row_c;
    assign base_o = base_c;
    assign size_o = size_c;
  end

  // lower-numbered row that also covers the address
  logic lower_hit;
  always_comb begin
    lower_hit = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (ROW_W'(j) < row_c && addr_i >= base_c[j] && addr_i < lim_c[j])
        lower_hit = 1'b1;
    end
  end

  p_first_base_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_c[0] == '0);

  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_c |-> row_c == '0);

  p_hit_in_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_c |-> (addr_i >= base_c[row_c] && addr_i < lim_c[row_c]));

  p_lowest_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_c |-> !lower_hit);

  for (genvar g = 0; g < N; g++) begin : g_chk
    p_top_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bnd_i[g] == '0 && base_c[g] != '0) |-> (lim_c[g] == TOP));
    p_empty_size_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lim_c[g] == base_c[g]) |-> (size_c[g] == '0));
    if (g < N - 1) begin : g_chain
      p_chain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        base_c[g+1] == base_c[g] || base_c[g+1] == lim_c[g]);
    end
  end
endmodule

// File: tb/rbd_decoder_test.sv
`timescale 1ns/1ps
module rbd_decoder_test;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0][7:0]   bnd = '0;
  logic [31:0]       addr = '0;
  logic              hit;
  logic [2:0]        row;
  logic [7:0][31:0]  base, size;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  rbd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .bnd_i(bnd), .addr_i(addr),
    .hit_o(hit), .row_o(row), .base_o(base), .size_o(size)
  );

  typedef struct packed {
    logic [63:0] cfg;
    logic [31:0] a;
    logic        h;
    logic [2:0]  r;
  } vec_t;

  localparam logic [63:0] CFG_A = 64'h0000_0000_0804_0402;
  localparam logic [63:0] CFG_B = 64'hFFFF_FF14_140A_0000;
  localparam logic [63:0] CFG_C = 64'h0000_0000_000C_0408;
  localparam logic [63:0] CFG_D = 64'h0;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{CFG_A, 32'h0000_0000, 1'b1, 3'd0},
    '{CFG_A, 32'h00FF_FFFF, 1'b1, 3'd0},
    '{CFG_A, 32'h0100_0000, 1'b1, 3'd1},
    '{CFG_A, 32'h0200_0000, 1'b1, 3'd3},
    '{CFG_A, 32'h03FF_FFFF, 1'b1, 3'd3},
    '{CFG_A, 32'h0400_0000, 1'b1, 3'd4},
    '{CFG_A, 32'h7FFF_FFFF, 1'b1, 3'd4},
    '{CFG_A, 32'h8000_0000, 1'b0, 3'd0},
    '{CFG_A, 32'hFFFF_FFFF, 1'b0, 3'd0},
    '{CFG_B, 32'h0000_0000, 1'b1, 3'd2},
    '{CFG_B, 32'h09FF_FFFF, 1'b1, 3'd3},
    '{CFG_B, 32'h7F7F_FFFF, 1'b1, 3'd5},
    '{CFG_B, 32'h7F80_0000, 1'b0, 3'd0},
    '{CFG_C, 32'h0300_0000, 1'b1, 3'd0},
    '{CFG_C, 32'h0500_0000, 1'b1, 3'd2},
    '{CFG_C, 32'h0600_0000, 1'b1, 3'd3},
    '{CFG_D, 32'h0000_0000, 1'b0, 3'd0},
    '{CFG_D, 32'h4000_0000, 1'b0, 3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected base/size built straight from the requirement text
  task automatic chk_map(input logic [63:0] cfg, input string tag);
    logic [31:0] run, lim;
    run = 0;
    for (int r = 0; r < 8; r++) begin
      logic [7:0] b;
      b = cfg[8*r +: 8];
      if (b == 0 && run != 0) lim = 32'h8000_0000;
      else lim = {1'b0, b, 23'b0};
      chk($sformatf("%s base row%0d", tag, r), base[r], run);
      chk($sformatf("%s size row%0d", tag, r), size[r], lim - run);
      if (lim != run) run = lim;
    end
  endtask

  task automatic apply(input logic [63:0] cfg, input logic [31:0] a);
    @(negedge clk);
    bnd  = cfg;
    addr = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: outputs held at zero during reset
    bnd = CFG_A; addr = 32'h0100_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset hit", 32'(hit), 0);
    chk("R9 reset row", 32'(row), 0);
    chk("R9 reset base1", base[1], 0);
    chk("R9 reset size0", size[0], 0);
    rst_n = 1'b1;

    // R6, R7: table walk
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].cfg, VECS[i].a);
      chk(VECS[i].h ? "R6 hit" : "R7 miss hit", 32'(hit), 32'(VECS[i].h));
      chk(VECS[i].h ? "R6 row" : "R7 miss row", 32'(row), 32'(VECS[i].r));
    end

    // R1, R2, R3, R4: empty row 2, top-of-memory at row 4
    apply(CFG_A, 0);
    chk_map(CFG_A, "R1/R3");
    chk("R4 top base row5", base[5], 32'h8000_0000);
    chk("R4 top size row4", size[4], 32'h7C00_0000);
    chk("R3 empty size row2", size[2], 0);
    // R5: leading zero rows, max boundary
    apply(CFG_B, 0);
    chk_map(CFG_B, "R5");
    chk("R1 limit row5", base[5] + size[5], 32'h7F80_0000);
    // R8: descending row wraps size, claims nothing
    apply(CFG_C, 0);
    chk_map(CFG_C, "R8");
    chk("R8 wrapped size row1", size[1], 32'hFE00_0000);
    apply(CFG_C, 32'h0400_0000);
    chk("R8 descending row skipped", 32'(row), 2);
    // R3 / R5: all empty
    apply(CFG_D, 0);
    chk_map(CFG_D, "R5 all zero");

    // R9: one cycle latency
    apply(CFG_A, 32'h0000_0010);
    @(negedge clk);
    addr = 32'h0400_0000;
    #1;
    chk("R9 before edge row", 32'(row), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 after edge row", 32'(row), 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule